// File: doc/BRIEF.md
# Serial Display Link Master with Data/Command Select

This block is the host side of a four-wire serial link to a small display controller. Besides chip select, clock and data, the link has a data/command select line. Every transaction opens with one command byte shifted with the select line low.

A write transaction then shifts a number of parameter bytes with the select line high. These bytes come from a valid/ready stream. A read transaction keeps chip select low after the command byte and clocks in the response bytes, which leave on a second valid/ready stream.

Two of the readable commands, identification (0x04) and status (0x09), have replies that begin with one dummy clock. For these the block fetches one extra byte and shifts the reply left by one bit. When a power-mode read (0x0A) completes, the block decodes the first reply byte into a display-on flag.

The clock rate depends on the phase. Command bytes and short parameter runs are limited to a moderate rate. Long parameter runs use the full link rate. Every byte of a read runs at a slow read rate. All rates are derived from parameters. The link uses mode 0: SCLK idles low, MOSI changes while SCLK is low, and both ends sample on the rising edge, MSB first.

Top module: `spi_dcx_link`

## Requirements
- R1: A request is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no transaction is in progress and no response byte is waiting in the output slot.
- R2: `spi_cs_n` is held low for the whole transaction, and SCLK is low whenever `spi_cs_n` is high. The command byte is shifted MSB first with `spi_dcx` low. In a write, each of the `cmd_len` parameter bytes that follow is shifted with `spi_dcx` high. `spi_dcx` changes only while SCLK is low.
- R3: Each parameter byte is taken on a `wr_valid`/`wr_ready` handshake. `wr_ready` is high only while the link waits for the next byte, with chip select low and SCLK held low. An empty stream pauses the link without ending the transaction.
- R4: The readable codes are 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. Any other code is a write. In a read, `cmd_len` response bytes are clocked in on MISO after the command byte. During a read `spi_dcx` stays low and MOSI sends zeros.
- R5: For codes 0x04 and 0x09, `cmd_len`+1 bytes b[0..] are clocked in. Output byte i equals {b[i][6:0], b[i+1][7]}.
- R6: A read is rejected if its length is zero, or if the code is 0x04 or 0x09 and the length is neither 3 nor 4. A rejected read pulses `err` for one cycle, does not pulse `done`, and causes no activity on chip select or SCLK.
- R7: `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low. The next response byte is not clocked until the slot has been emptied, and SCLK stays low while the link waits.
- R8: Let H(f) = ceil(CLK_HZ / (2 f)) be the number of clock cycles SCLK spends in each half period at rate f. The command byte and the parameters of a write with `cmd_len` ≤ SHORT_MAX use H(min(CMD_CAP_HZ, LINK_MAX_HZ)). Parameters of a longer write use H(LINK_MAX_HZ). Every byte of a read uses H(min(READ_CAP_HZ, LINK_MAX_HZ/2)).
- R9: After a read of code 0x0A, `disp_on_vld` is high. `disp_on` is 1 exactly when (first reply byte AND 0x7C) equals 0x1C.
- R10: `done` pulses for one cycle, in the cycle where `spi_cs_n` returns high at the end of a transaction.
- R11: After reset, `spi_cs_n` is 1. `spi_sclk`, `spi_dcx`, `rd_valid`, `done`, `err` and `disp_on_vld` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request may be accepted |
| cmd_code | input | 8 | Command byte |
| cmd_len | input | LEN_W | Parameter or response byte count |
| wr_valid | input | 1 | Parameter byte valid |
| wr_ready | output | 1 | Link waits for a parameter byte |
| wr_data | input | 8 | Parameter byte |
| rd_valid | output | 1 | Response byte valid |
| rd_ready | input | 1 | Consumer takes response byte |
| rd_data | output | 8 | Response byte, realigned where needed |
| done | output | 1 | Transaction finished pulse |
| err | output | 1 | Rejected read pulse |
| disp_on | output | 1 | Decoded display-on flag |
| disp_on_vld | output | 1 | A power-mode read has completed |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_dcx | output | 1 | Data/command select, low for command |

## Verification
The bench drives the identification and status reads at both legal lengths with random reply bits. A block that dropped the extra byte or shifted the wrong way would return bytes off by one bit, or would show a short transfer count on the bus.

It sends illegal read lengths (zero, 2 and 5). A block that did not check them would lower chip select or raise `done`.

It stalls both streams at random. A block with broken back-pressure would toggle SCLK during a stall or change a held response byte. Power-mode replies with reserved bits set and cleared expose a wrong mask. Measured SCLK high times on short writes, on a write longer than the threshold and on reads expose a wrong rate choice.

// File: rtl/spi_dcx_pkg.sv
package spi_dcx_pkg;

  localparam logic [7:0] OP_DISP_ID   = 8'h04;
  localparam logic [7:0] OP_DISP_STAT = 8'h09;
  localparam logic [7:0] OP_PWR_MODE  = 8'h0A;

  localparam logic [7:0] PWR_KEEP_MASK  = 8'h7C;
  localparam logic [7:0] PWR_ON_PATTERN = 8'h1C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_PWAIT,
    ST_PARAM,
    ST_RWAIT,
    ST_RESP
  } link_state_t;

  function automatic logic pwr_is_on(input logic [7:0] b);
    return (b & PWR_KEEP_MASK) == PWR_ON_PATTERN;
  endfunction

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // clock cycles per SCLK half period, rounded up so the rate never exceeds f
  function automatic int unsigned half_cycles(input int unsigned clk_hz, input int unsigned f_hz);
    longint unsigned den;
    longint unsigned q;
    if (f_hz == 0) return 1;
    den = 2 * longint'(f_hz);
    q = (longint'(clk_hz) + den - 1) / den;
    return (q == 0) ? 1 : int'(q);
  endfunction

endpackage

// File: rtl/spi_dcx_decode.sv
module spi_dcx_decode #(
  parameter int unsigned LEN_W = 8
) (
  input  logic [7:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic             is_rd,
  output logic             needs_dummy,
  output logic             len_ok,
  output logic             is_pwr
);
  import spi_dcx_pkg::*;

  always_comb begin
    case (code)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
      8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
      8'h56, 8'h5F, 8'hA1, 8'hA8: is_rd = 1'b1;
      default:                    is_rd = 1'b0;
    endcase
  end

  assign needs_dummy = (code == OP_DISP_ID) || (code == OP_DISP_STAT);
  assign is_pwr      = (code == OP_PWR_MODE);

  always_comb begin
    if (!is_rd)
      len_ok = 1'b1;
    else if (len == '0)
      len_ok = 1'b0;
    else if (needs_dummy)
      len_ok = (len == LEN_W'(3)) || (len == LEN_W'(4));
    else
      len_ok = 1'b1;
  end

endmodule

// File: rtl/spi_dcx_shifter.sv
module spi_dcx_shifter #(
  parameter int unsigned HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    tx_byte,
  input  logic [HW-1:0] half_len,
  input  logic          miso,
  output logic          done,
  output logic [7:0]    rx_byte,
  output logic          sclk,
  output logic          mosi
);
  logic          busy;
  logic          hi;
  logic [HW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hi    <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          tx_sh <= tx_byte;
          bitn  <= '0;
          hi    <= 1'b0;
          cnt   <= '0;
        end
      end else if (cnt == half_len - HW'(1)) begin
        cnt <= '0;
        if (!hi) begin
          hi    <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          hi <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn  <= bitn + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end

  assign sclk    = hi;
  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_dcx_realign.sv
module spi_dcx_realign (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       dummy,
  input  logic       in_stb,
  input  logic [7:0] in_byte,
  output logic       out_stb,
  output logic [7:0] out_byte
);
  logic [6:0] prev_lo;
  logic       first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lo <= '0;
      first   <= 1'b1;
    end else if (clear) begin
      first <= 1'b1;
    end else if (in_stb) begin
      first   <= 1'b0;
      prev_lo <= in_byte[6:0];
    end
  end

  // dummy-clock replies: the first captured byte only seeds the merge
  assign out_stb  = in_stb && !(dummy && first);
  assign out_byte = dummy ? {prev_lo, in_byte[7]} : in_byte;

endmodule

// File: rtl/spi_dcx_link.sv
module spi_dcx_link #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned LINK_MAX_HZ = 25_000_000,
  parameter int unsigned CMD_CAP_HZ  = 10_000_000,
  parameter int unsigned READ_CAP_HZ = 2_000_000,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SHORT_MAX   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_code,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             disp_on,
  output logic             disp_on_vld,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_dcx
);
  import spi_dcx_pkg::*;

  localparam int unsigned CMD_HZ    = umin(CMD_CAP_HZ, LINK_MAX_HZ);
  localparam int unsigned RD_HZ     = umin(READ_CAP_HZ, LINK_MAX_HZ / 2);
  localparam int unsigned HALF_CMD  = half_cycles(CLK_HZ, CMD_HZ);
  localparam int unsigned HALF_FAST = half_cycles(CLK_HZ, LINK_MAX_HZ);
  localparam int unsigned HALF_RD   = half_cycles(CLK_HZ, RD_HZ);
  localparam int unsigned HALF_MAX  = umax(HALF_RD, umax(HALF_CMD, HALF_FAST));
  localparam int unsigned HW        = $clog2(HALF_MAX + 1);
  localparam int unsigned RW        = LEN_W + 1;

  link_state_t   state;
  logic [RW-1:0] rem;
  logic          rd_mode, dummy_mode, pm_mode, fast_param;
  logic [HW-1:0] half_sel;
  logic          cs_n_q, dcx_q, done_q, err_q;
  logic          start_q;
  logic [7:0]    tx_q;
  logic          rd_valid_q;
  logic [7:0]    rd_data_q;
  logic          pwr_on_q, pwr_vld_q;

  logic dec_rd, dec_dummy, dec_len_ok, dec_pwr;
  logic sh_done;
  logic [7:0] sh_rx;
  logic ra_stb;
  logic [7:0] ra_byte;
  logic accept, take_wr, rd_take, long_req;

  spi_dcx_decode #(.LEN_W(LEN_W)) dec_i (
    .code        (cmd_code),
    .len         (cmd_len),
    .is_rd       (dec_rd),
    .needs_dummy (dec_dummy),
    .len_ok      (dec_len_ok),
    .is_pwr      (dec_pwr)
  );

  spi_dcx_shifter #(.HW(HW)) sh_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_q),
    .tx_byte  (tx_q),
    .half_len (half_sel),
    .miso     (spi_miso),
    .done     (sh_done),
    .rx_byte  (sh_rx),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi)
  );

  spi_dcx_realign ra_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .dummy    (dummy_mode),
    .in_stb   (sh_done && (state == ST_RESP)),
    .in_byte  (sh_rx),
    .out_stb  (ra_stb),
    .out_byte (ra_byte)
  );

  assign cmd_ready = (state == ST_IDLE) && !rd_valid_q;
  assign wr_ready  = (state == ST_PWAIT);
  assign accept    = cmd_valid && cmd_ready;
  assign take_wr   = wr_valid && wr_ready;
  assign rd_take   = rd_valid_q && rd_ready;
  assign long_req  = {{(32-LEN_W){1'b0}}, cmd_len} > 32'(SHORT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rem        <= '0;
      rd_mode    <= 1'b0;
      dummy_mode <= 1'b0;
      pm_mode    <= 1'b0;
      fast_param <= 1'b0;
      half_sel   <= HW'(HALF_CMD);
      cs_n_q     <= 1'b1;
      dcx_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      start_q    <= 1'b0;
      tx_q       <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      pwr_on_q   <= 1'b0;
      pwr_vld_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;

      if (rd_take) rd_valid_q <= 1'b0;
      if (ra_stb) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= ra_byte;
        if (pm_mode) begin
          pwr_on_q  <= pwr_is_on(ra_byte);
          pwr_vld_q <= 1'b1;
          pm_mode   <= 1'b0;
        end
      end

      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_rd && !dec_len_ok) begin
              err_q <= 1'b1;
            end else begin
              cs_n_q     <= 1'b0;
              dcx_q      <= 1'b0;
              start_q    <= 1'b1;
              tx_q       <= cmd_code;
              rd_mode    <= dec_rd;
              dummy_mode <= dec_rd && dec_dummy;
              pm_mode    <= dec_rd && dec_pwr;
              fast_param <= long_req;
              half_sel   <= dec_rd ? HW'(HALF_RD) : HW'(HALF_CMD);
              rem        <= {1'b0, cmd_len} + RW'(dec_rd && dec_dummy);
              state      <= ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (sh_done) begin
            if (rd_mode) begin
              state <= ST_RWAIT;
            end else if (rem == '0) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              half_sel <= fast_param ? HW'(HALF_FAST) : HW'(HALF_CMD);
              state    <= ST_PWAIT;
            end
          end
        end
        ST_PWAIT: begin
          if (take_wr) begin
            dcx_q   <= 1'b1;
            tx_q    <= wr_data;
            start_q <= 1'b1;
            rem     <= rem - RW'(1);
            state   <= ST_PARAM;
          end
        end
        ST_PARAM: begin
          if (sh_done) begin
            if (rem == '0) begin
              cs_n_q <= 1'b1;
              dcx_q  <= 1'b0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_PWAIT;
            end
          end
        end
        ST_RWAIT: begin
          if (!rd_valid_q) begin
            tx_q    <= 8'h00;
            start_q <= 1'b1;
            rem     <= rem - RW'(1);
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (sh_done) begin
            if (rem == '0) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_RWAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n    = cs_n_q;
  assign spi_dcx     = dcx_q;
  assign done        = done_q;
  assign err         = err_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign disp_on     = pwr_on_q;
  assign disp_on_vld = pwr_vld_q;

endmodule

// File: rtl/spi_dcx_link_chk.sv
module spi_dcx_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       err,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       spi_dcx
);

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n);

  a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r2_dcx_stable_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_dcx));

  a_r3_wr_wait_paused: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !spi_sclk));

  a_r6_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (spi_cs_n && !done));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));

endmodule

bind spi_dcx_link spi_dcx_link_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .err       (err),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_dcx   (spi_dcx)
);

// File: tb/spi_dcx_link_tb.sv
module spi_dcx_link_tb_top;

  localparam int CLK_HZ = 125_000_000;

  function automatic int hc(input int f);
    return (CLK_HZ + 2 * f - 1) / (2 * f);
  endfunction

  localparam int EXP_CMD  = (CLK_HZ + 20_000_000 - 1) / 20_000_000;
  localparam int EXP_FAST = (CLK_HZ + 50_000_000 - 1) / 50_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [7:0] cmd_len = '0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_ready = 1'b0;
  logic miso = 1'b0;
  logic cmd_ready, wr_ready, rd_valid, done, err, disp_on, disp_on_vld;
  logic [7:0] rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_dcx;

  int n_chk = 0;
  int n_err = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int cs_falls = 0;

  logic [7:0] resp [0:7];
  logic [7:0] lg_b [0:127];
  logic       lg_dc [0:127];
  int         lg_hi [0:127];
  int n_log = 0;
  int nb = 0;
  logic [7:0] shreg = '0;
  logic cs_prev = 1'b1;
  logic sk_prev = 1'b0;
  time t_rise = 0;

  always #4 clk = ~clk;

  spi_dcx_link dut_i (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_code (cmd_code), .cmd_len (cmd_len),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
    .done (done), .err (err), .disp_on (disp_on), .disp_on_vld (disp_on_vld),
    .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi),
    .spi_miso (miso), .spi_dcx (spi_dcx)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (err) err_cnt++;
    end
  end

  function automatic logic resp_bit(input int n);
    int j;
    if (n < 8) return 1'b0;
    j = n - 8;
    if (j / 8 > 7) return 1'b0;
    return resp[j / 8][7 - (j % 8)];
  endfunction

  // display-side model: logs shifted bytes and drives the reply
  always @(spi_sclk or spi_cs_n) begin
    if (spi_cs_n !== cs_prev) begin
      if (spi_cs_n === 1'b0) begin
        nb = 0;
        cs_falls++;
      end
      cs_prev = spi_cs_n;
    end
    if (spi_sclk !== sk_prev) begin
      if (spi_sclk === 1'b1 && spi_cs_n === 1'b0) begin
        shreg = {shreg[6:0], spi_mosi};
        nb++;
        t_rise = $time;
        if (nb % 8 == 0 && n_log < 128) begin
          lg_b[n_log]  = shreg;
          lg_dc[n_log] = spi_dcx;
        end
      end else if (spi_sclk === 1'b0 && sk_prev === 1'b1) begin
        miso = resp_bit(nb);
        if (nb % 8 == 0 && n_log < 128) begin
          lg_hi[n_log] = int'(($time - t_rise) / 8);
          n_log++;
        end
      end
      sk_prev = spi_sclk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] code, input int len);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_len   = 8'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_write(input logic [7:0] code, input int len);
    logic [7:0] pb [0:127];
    int d0, bad_b, bad_hi, exp_hi, paused_bad;
    for (int i = 0; i < len; i++) pb[i] = 8'($urandom);
    n_log = 0;
    d0 = done_cnt;
    paused_bad = 0;
    send_cmd(code, len);
    check(!cmd_ready, "R1", "cmd_ready during write", int'(cmd_ready), 0);
    for (int i = 0; i < len; i++) begin
      repeat ($urandom % 4) begin
        @(negedge clk);
        if (wr_ready && (spi_sclk || spi_cs_n)) paused_bad++;
      end
      wr_valid = 1'b1;
      wr_data  = pb[i];
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
    end
    wait_done(d0);
    check(paused_bad == 0, "R3", "sclk/cs while waiting for param", paused_bad, 0);
    check(n_log == len + 1, "R2", "write byte count", n_log, len + 1);
    check(lg_b[0] == code && lg_dc[0] == 1'b0, "R2", "command byte", int'(lg_b[0]), int'(code));
    bad_b = 0;
    bad_hi = (lg_hi[0] != EXP_CMD) ? 1 : 0;
    exp_hi = (len > 64) ? EXP_FAST : EXP_CMD;
    for (int i = 0; i < len && i + 1 < n_log; i++) begin
      if (lg_b[i+1] != pb[i] || lg_dc[i+1] != 1'b1) bad_b++;
      if (lg_hi[i+1] != exp_hi) bad_hi++;
    end
    if (len > 0) check(bad_b == 0, "R2", "param bytes/dcx mismatches", bad_b, 0);
    check(bad_hi == 0, "R8", "write sclk half periods wrong", bad_hi, 0);
    if (len > 0 && n_log > 1) check(lg_hi[1] == exp_hi, "R8", "param half period", lg_hi[1], exp_hi);
    check(spi_cs_n == 1'b1, "R10", "cs released after done", int'(spi_cs_n), 1);
  endtask

  task automatic run_read(input logic [7:0] code, input int len, input bit dmy);
    logic [7:0] got [0:7];
    int d0, ngot, bad, held;
    logic [7:0] hold_v, ex;
    n_log = 0;
    d0 = done_cnt;
    ngot = 0;
    held = 0;
    send_cmd(code, len);
    while (ngot < len) begin
      @(negedge clk);
      rd_ready = 1'($urandom % 2);
      if (rd_valid && rd_ready) begin
        got[ngot] = rd_data;
        ngot++;
      end else if (rd_valid && held == 0) begin
        held = 1;
        hold_v = rd_data;
        repeat (3) @(negedge clk);
        check(rd_valid && rd_data == hold_v && !spi_sclk, "R7", "held byte / paused bus",
              int'(rd_data), int'(hold_v));
      end
    end
    @(negedge clk);
    rd_ready = 1'b0;
    wait_done(d0);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      ex = dmy ? {resp[i][6:0], resp[i+1][7]} : resp[i];
      if (got[i] != ex) begin
        bad++;
        $display("FAIL %s read byte %0d actual=%0h expected=%0h", dmy ? "R5" : "R4", i, got[i], ex);
      end
    end
    n_chk++;
    if (bad != 0) n_err++;
    check(n_log == 1 + len + int'(dmy), dmy ? "R5" : "R4", "bytes clocked", n_log, 1 + len + int'(dmy));
    bad = 0;
    for (int i = 0; i < n_log; i++) begin
      if (lg_dc[i] != 1'b0) bad++;
      if (i > 0 && lg_b[i] != 8'h00) bad++;
    end
    check(bad == 0 && lg_b[0] == code, "R4", "read command/dcx/mosi", bad, 0);
    bad = 0;
    for (int i = 0; i < n_log; i++) if (lg_hi[i] != hc(2_000_000)) bad++;
    check(bad == 0, "R8", "read half periods wrong", bad, 0);
  endtask

  task automatic run_bad(input logic [7:0] code, input int len);
    int e0, d0, c0;
    e0 = err_cnt; d0 = done_cnt; c0 = cs_falls;
    send_cmd(code, len);
    repeat (4) @(negedge clk);
    check(err_cnt == e0 + 1, "R6", "err pulses", err_cnt - e0, 1);
    check(cs_falls == c0 && done_cnt == d0, "R6", "bus activity on rejected read",
          cs_falls - c0, 0);
  endtask

  task automatic run_pwr(input logic [7:0] b);
    resp[0] = b;
    run_read(8'h0A, 1, 1'b0);
    check(disp_on_vld && disp_on == ((b & 8'h7C) == 8'h1C), "R9", "display-on decode",
          int'(disp_on), int'((b & 8'h7C) == 8'h1C));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) resp[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !spi_dcx && !rd_valid && !done && !err && !disp_on_vld,
          "R11", "outputs in reset", int'(spi_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", int'(cmd_ready), 1);

    run_write(8'h2A, 4);
    run_write(8'h11, 0);
    run_write(8'h2C, 70);
    run_read(8'h0B, 2, 1'b0);
    run_read(8'h04, 3, 1'b0 | 1'b1);
    run_read(8'h09, 4, 1'b1);
    run_bad(8'h04, 2);
    run_bad(8'h09, 5);
    run_bad(8'h0A, 0);
    run_pwr(8'h9C);
    run_pwr(8'h1D);
    run_pwr(8'h18);
    run_pwr(8'h3C);

    for (int k = 0; k < 14; k++) begin
      for (int i = 0; i < 8; i++) resp[i] = 8'($urandom);
      case ($urandom % 5)
        0: run_write(8'h2C, int'($urandom % 9));
        1: run_read(8'h06, 1 + int'($urandom % 3), 1'b0);
        2: run_read(($urandom % 2) ? 8'h04 : 8'h09, 3 + int'($urandom % 2), 1'b1);
        3: run_pwr(8'($urandom));
        default: run_write(8'h36, 1);
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule